// File: doc/BRIEF.md
# Consecutive Byte Write Sequencer

This block turns one accepted command (a 16-bit start address, a byte count and a payload already placed in a local byte store) into a run of single-byte writes on an internal register bus. For each byte it puts the address and the byte on the bus for one clock, then raises the write strobe for exactly one clock. It then steps the address by one and moves on to the next stored byte until the count is used up. It knows nothing about the width of the targets it writes: a run may cross from one target into the next, and each receiver decides for itself when it holds a complete word.

The payload is loaded through a simple indexed byte-write port before the command is issued. The command is a single-cycle `cmd_start` pulse that the framing logic raises only after a frame has passed its checks. While a run is in progress `busy` is high. One clock after the last strobe, a single-cycle `done` pulse closes the run.

The controller has four states. IDLE waits for a command. SETUP drives address and data with the strobe low. STROBE raises the strobe. FINISH raises `done`. The transitions are:
- IDLE to SETUP on a start with a non-zero count.
- IDLE to FINISH on a start with a zero count.
- SETUP to STROBE always.
- STROBE to SETUP when bytes remain, with the address and index stepped.
- STROBE to FINISH after the last byte.
- FINISH to IDLE always.

Top module: `byte_write_seq`

## Requirements
- R1: After reset `wr_stb`, `busy` and `done` are low and `wr_addr` is 0x0000.
- R2: The first strobe of a run carries `cmd_addr` on `wr_addr` and the byte stored at payload index 0 on `wr_data`.
- R3: Each later strobe carries the previous strobe's address plus one and the next payload index; the address wraps from 0xFFFF to 0x0000.
- R4: `wr_stb` is high for exactly one clock per byte, with at least one low clock between strobes; a start sampled at edge P puts strobe k (k counted from 0) in the clock after edge P+2k+1.
- R5: In the clock before each strobe, `wr_addr` and `wr_data` already hold that strobe's address and byte, and they do not change into the strobe clock.
- R6: The number of strobes equals the command's byte count. `busy` is high from the clock after the start up to and including the last strobe clock. `done` is high for one clock, the clock right after the last strobe.
- R7: A byte count of zero produces no strobe, keeps `busy` low, and raises `done` in the clock after the start.
- R8: Byte counts above 64 are treated as 64.
- R9: A start pulse is taken only in IDLE. A start during SETUP, STROBE or FINISH changes nothing in the run under way.
- R10: A byte written through the load port with `pl_idx` = i (0 is the first byte) is the byte sent on the strobe numbered i of the next run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pl_we | input | 1 | Payload store write enable |
| pl_idx | input | 6 | Payload store byte index |
| pl_byte | input | 8 | Payload byte to store |
| cmd_start | input | 1 | One-cycle pulse marking a validated command |
| cmd_addr | input | 16 | Start address of the run |
| cmd_len | input | 8 | Number of bytes to write |
| wr_addr | output | 16 | Register bus address |
| wr_data | output | 8 | Register bus data byte |
| wr_stb | output | 1 | Register bus write strobe, one clock per byte |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse after the last write |

## Verification
The bench aims at the count limits: one byte, zero bytes, exactly 64 and counts well above 64. A design that mishandles these loses or adds a strobe, misses its done pulse, or reads past the store. A run that starts at 0xFFFE shows whether the address wraps or grows into a carry. Start pulses are placed in the SETUP, STROBE and FINISH clocks; a design that takes them would restart or stretch the run. Random runs with a changing payload compare every address and byte against a model of the store, which exposes off-by-one indexing, wrong byte order, and setup values that change at the strobe.

// File: rtl/byte_write_seq_pkg.sv
package byte_write_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_FINISH = 2'd3
    } seq_state_e;

endpackage

// File: rtl/seq_payload_store.sv
module seq_payload_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_byte
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_idx] <= wr_byte;
        end
    end

    assign rd_byte = cells[rd_idx];

endmodule

// File: rtl/seq_cursor.sv
module seq_cursor #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 8,
    parameter int DEPTH  = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              begin_run,
    input  logic              advance,
    input  logic [ADDR_W-1:0] first_addr,
    input  logic [LEN_W-1:0]  byte_count,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [IDX_W-1:0]  cur_idx,
    output logic              last_byte
);

    logic [CNT_W-1:0] remaining;
    logic [CNT_W-1:0] clamped;

    // Counts beyond the store depth are limited to the depth
    always_comb begin
        if (byte_count > LEN_W'(DEPTH)) begin
            clamped = CNT_W'(DEPTH);
        end else begin
            clamped = CNT_W'(byte_count);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            cur_idx   <= '0;
            remaining <= '0;
        end else if (begin_run) begin
            cur_addr  <= first_addr;
            cur_idx   <= '0;
            remaining <= clamped;
        end else if (advance) begin
            cur_addr  <= cur_addr + 1'b1;
            cur_idx   <= cur_idx + 1'b1;
            remaining <= remaining - 1'b1;
        end
    end

    assign last_byte = (remaining == CNT_W'(1));

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import byte_write_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic len_zero,
    input  logic last_byte,
    output logic begin_run,
    output logic advance,
    output logic stb,
    output logic busy,
    output logic done
);

    seq_state_e state_q;
    seq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = len_zero ? ST_FINISH : ST_SETUP;
                end
            end
            ST_SETUP:  state_d = ST_STROBE;
            ST_STROBE: state_d = last_byte ? ST_FINISH : ST_SETUP;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        begin_run = 1'b0;
        advance   = 1'b0;
        stb       = 1'b0;
        busy      = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                begin_run = start && !len_zero;
            end
            ST_SETUP: begin
                busy = 1'b1;
            end
            ST_STROBE: begin
                busy    = 1'b1;
                stb     = 1'b1;
                advance = !last_byte;
            end
            ST_FINISH: begin
                done = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/byte_write_seq.sv
module byte_write_seq #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    parameter int LEN_W  = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pl_we,
    input  logic [IDX_W-1:0]  pl_idx,
    input  logic [DATA_W-1:0] pl_byte,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_stb,
    output logic              busy,
    output logic              done
);

    logic             begin_run;
    logic             advance;
    logic             last_byte;
    logic [IDX_W-1:0] cur_idx;

    seq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cmd_start),
        .len_zero  (cmd_len == '0),
        .last_byte (last_byte),
        .begin_run (begin_run),
        .advance   (advance),
        .stb       (wr_stb),
        .busy      (busy),
        .done      (done)
    );

    seq_cursor #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .DEPTH  (DEPTH)
    ) u_cursor (
        .clk        (clk),
        .rst_n      (rst_n),
        .begin_run  (begin_run),
        .advance    (advance),
        .first_addr (cmd_addr),
        .byte_count (cmd_len),
        .cur_addr   (wr_addr),
        .cur_idx    (cur_idx),
        .last_byte  (last_byte)
    );

    seq_payload_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk     (clk),
        .wr_en   (pl_we),
        .wr_idx  (pl_idx),
        .wr_byte (pl_byte),
        .rd_idx  (cur_idx),
        .rd_byte (wr_data)
    );

endmodule

// File: rtl/byte_write_seq_chk.sv
module byte_write_seq_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_stb,
    input logic              busy,
    input logic              done
);

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R4

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $stable(wr_addr)); // R5

    AST_SETUP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(busy) && !$past(wr_stb)); // R5

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && $past(wr_stb, 2)) |-> (wr_addr == $past(wr_addr, 2) + 1'b1)); // R3

    AST_STB_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> busy); // R6

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done && $past(wr_stb)); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy)); // R7

    AST_DATA_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !$isunknown(wr_data)); // R2

endmodule

bind byte_write_seq byte_write_seq_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wr_stb  (wr_stb),
    .busy    (busy),
    .done    (done)
);

// File: tb/byte_write_seq_tb.sv
module byte_write_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pl_we = 1'b0;
    logic [5:0]  pl_idx = '0;
    logic [7:0]  pl_byte = '0;
    logic        cmd_start = 1'b0;
    logic [15:0] cmd_addr = '0;
    logic [7:0]  cmd_len = '0;
    logic [15:0] wr_addr;
    logic [7:0]  wr_data;
    logic        wr_stb;
    logic        busy;
    logic        done;

    int total = 0;
    int bad = 0;
    logic [7:0] model [64];

    byte_write_seq u_dut (
        .clk(clk), .rst_n(rst_n), .pl_we(pl_we), .pl_idx(pl_idx), .pl_byte(pl_byte),
        .cmd_start(cmd_start), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_stb(wr_stb), .busy(busy), .done(done)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int eff_len(input int n);
        return (n > 64) ? 64 : n;
    endfunction

    function automatic logic [15:0] exp_addr(input logic [15:0] base, input int k);
        return base + 16'(k);
    endfunction

    task automatic load(input int i, input logic [7:0] v);
        pl_we = 1'b1; pl_idx = 6'(i); pl_byte = v;
        @(negedge clk);
        pl_we = 1'b0;
        model[i] = v;
    endtask

    // Runs one command; glitch_j>0 drives an extra start in that cycle (R9)
    task automatic run(input logic [15:0] a, input int len, input int glitch_j);
        int n;
        logic [15:0] ea;
        n = eff_len(len);
        cmd_start = 1'b1; cmd_addr = a; cmd_len = 8'(len);
        for (int j = 1; j <= 2 * n + 2; j++) begin
            @(negedge clk);
            cmd_start = 1'b0;
            // R4 strobe pattern, R6 busy/done, R7 zero length
            check(wr_stb == ((j % 2 == 0) && j >= 2 && j <= 2 * n), "R4", int'(wr_stb), j);
            check(busy == (j >= 1 && j <= 2 * n), "R6", int'(busy), j);
            check(done == (j == 2 * n + 1), (n == 0) ? "R7" : "R6", int'(done), j);
            if (j >= 1 && j <= 2 * n) begin
                ea = exp_addr(a, (j - 1) / 2);
                // R2 first byte, R3 later bytes and wrap, R5 setup cycle, R10 load order
                check(wr_addr == ea, (j <= 2) ? "R2" : "R3", int'(wr_addr), int'(ea));
                check(wr_data == model[(j - 1) / 2], (j % 2 == 1) ? "R5" : "R10",
                      int'(wr_data), int'(model[(j - 1) / 2]));
            end
            if (j == glitch_j) begin
                cmd_start = 1'b1; cmd_addr = ~a; cmd_len = 8'd3;
            end
        end
        cmd_start = 1'b0;
    endtask

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        int len;
        seed = $urandom(32'h1234_5678);
        for (int i = 0; i < 64; i++) model[i] = 'x;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!wr_stb && !busy && !done, "R1", {wr_stb, busy, done}, 0);
        check(wr_addr == 16'h0000, "R1", int'(wr_addr), 0);
        for (int i = 0; i < 64; i++) load(i, 8'($urandom));
        // R2 single byte
        run(16'h0200, 1, 0);
        // R7 zero length, with a start attempt in the done cycle (R9)
        run(16'h1234, 0, 1);
        // R3 address wrap
        run(16'hFFFE, 4, 0);
        // R8 exact depth and above
        run(16'h4000, 64, 0);
        run(16'h5000, 200, 0);
        run(16'h6000, 255, 0);
        // R9 start in setup, strobe and finish cycles
        run(16'h0300, 3, 1);
        run(16'h0310, 3, 2);
        run(16'h0320, 3, 7);
        // R10 reload bytes, then random runs
        load(0, 8'hA5); load(1, 8'h5A); load(63, 8'hC3);
        run(16'h0400, 2, 0);
        for (int r = 0; r < 40; r++) begin
            for (int k = 0; k < 4; k++) load(int'($urandom_range(0, 63)), 8'($urandom));
            len = int'($urandom_range(0, 90));
            run(16'($urandom), len,
                ($urandom_range(0, 2) == 0) ? int'($urandom_range(1, 2 * eff_len(len) + 1)) : 0);
            repeat (int'($urandom_range(0, 2))) @(negedge clk);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule